// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counter Timer

This block is a general-purpose timer that sits on a simple 32-bit register bus. The bus carries a byte offset, a write strobe and a read strobe. Software sets a 16-bit clock divider and a reload limit, then sets the run bit. The count then climbs by one every divider-plus-one clocks. When the count has reached the limit, the next tick returns it to zero. That wrap is the update event. It raises a sticky status flag and, if software allowed it, a one-clock interrupt pulse.

Software can place any value in the count at any time. It can also force a clean restart from zero through the event register. The flag is cleared by a masked write. The bus window also holds a set of configuration words for compare, trigger and transfer functions. These words are kept as plain storage and have no effect on counting.

Top module: `upcount_timer`

## Requirements
- R1: After reset, every register reads 0 and the interrupt output is low. The registers are control 0x00, interrupt enable 0x0C, status 0x10, count 0x24, divider 0x28, reload 0x2C and all storage words.
- R2: The count changes only while bit 0 of the control word (0x00) is 1. With that bit at 0, the count holds its value unless software writes it.
- R3: While running, the count rises by one once every (D+1) clocks, where D is the divider value. The divider word (0x28) keeps only bits 15:0 of a write.
- R4: When a tick arrives while the count equals a nonzero reload value (0x2C), the count becomes 0 and an update event occurs.
- R5: On an update event with bit 0 of the interrupt-enable word (0x0C) at 1, status bit 0 (0x10) becomes 1 at the same edge, and the interrupt output is high for exactly one clock. With that enable bit at 0, the flag does not change and the output stays low.
- R6: A write to the status word ANDs the stored bits with the write data. A 0 clears a bit and a 1 leaves it unchanged. An update event in the same cycle wins over the clear.
- R7: Writing the event word (0x14) with bit 0 set makes the count 0 and restarts the divider phase. The event word always reads 0.
- R8: A write to the count word (0x24) loads the written value as the count on the next edge. That cycle does not also tick.
- R9: With a reload value of 0, no update event, status flag or interrupt is produced. The count runs from its maximum to 0 silently.
- R10: A divider write leaves the count unchanged and restarts the divider phase. The next tick comes after (new D + 1) clocks.
- R11: Storage words at 0x04, 0x08, 0x18, 0x1C, 0x20, 0x34 to 0x40 and 0x48 to 0x50 read back what was written. Every other offset reads 0 and ignores writes, and so does any offset whose two low bits are not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte offset inside the 0x400-byte window |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busRdEn | input | 1 | Read strobe; read data is valid in the same clock |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data; 0 when no read is requested |
| irqPulse | output | 1 | One-clock update interrupt |

## Verification
The assertions assume two things about the bus. The write and read strobes are never left asserted on one offset across many clocks. Each write strobe stands for one clean access, so for example a held event-word write would restart the count every cycle.

The bench follows this rule by driving every access as a single-cycle strobe at the falling edge. It also sets up the divider, reload and count with the run bit at 0, then sets the run bit last. Because of this, every expected count comes from a known starting phase.

// File: rtl/uct_pkg.sv
package uct_pkg;

  // one-cycle strobes from the register decoder to the counting datapath
  typedef struct packed {
    logic restart;   // event-word write with bit 0 set
    logic loadCnt;   // write to the count word
    logic pscWrite;  // write to the divider word
  } uctStrobe_t;

  localparam logic [31:0] OFF_CTL1   = 32'h00;
  localparam logic [31:0] OFF_IRQEN  = 32'h0C;
  localparam logic [31:0] OFF_STATUS = 32'h10;
  localparam logic [31:0] OFF_EVGEN  = 32'h14;
  localparam logic [31:0] OFF_COUNT  = 32'h24;
  localparam logic [31:0] OFF_PSC    = 32'h28;
  localparam logic [31:0] OFF_RELOAD = 32'h2C;

  localparam int N_STORE = 12;

  // byte offsets of words that are plain read/write storage
  function automatic logic [31:0] storeOffset(input int idx);
    logic [31:0] off;
    case (idx)
      0:       off = 32'h04;
      1:       off = 32'h08;
      2:       off = 32'h18;
      3:       off = 32'h1C;
      4:       off = 32'h20;
      5:       off = 32'h34;
      6:       off = 32'h38;
      7:       off = 32'h3C;
      8:       off = 32'h40;
      9:       off = 32'h48;
      10:      off = 32'h4C;
      default: off = 32'h50;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/uct_datapath.sv
module uct_datapath
  import uct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [PSC_W-1:0] pscVal,
  input  logic [CNT_W-1:0] arrVal,
  input  logic [CNT_W-1:0] loadVal,
  input  uctStrobe_t       stb,
  output logic [CNT_W-1:0] cntVal,
  output logic             updEvent
);

  logic [PSC_W-1:0] phase;
  logic             phaseEnd;
  logic             tick;
  logic             wrapHit;

  assign phaseEnd = (phase == pscVal);
  assign tick     = enable && phaseEnd && !stb.restart && !stb.loadCnt && !stb.pscWrite;
  assign wrapHit  = (arrVal != '0) && (cntVal == arrVal);
  assign updEvent = tick && wrapHit;

  // divider phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (stb.restart || stb.pscWrite) begin
      phase <= '0;
    end else if (enable) begin
      phase <= phaseEnd ? '0 : phase + 1'b1;
    end
  end

  // main count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (stb.restart) begin
      cntVal <= '0;
    end else if (stb.loadCnt) begin
      cntVal <= loadVal;
    end else if (tick) begin
      cntVal <= wrapHit ? '0 : cntVal + 1'b1;
    end
  end

  // R2: stopped counter holds unless software touches it
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !stb.loadCnt && !stb.restart) |=> $stable(cntVal))
    else $error("count moved while stopped");

  // R3: without software writes the count steps by at most one or wraps to 0
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadCnt && !stb.restart) |=>
      ((cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1) || (cntVal == '0)))
    else $error("count jumped");

  // R4: update event leaves the count at zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    updEvent |=> (cntVal == '0))
    else $error("count not zero after update");

  // R7: restart strobe clears the count
  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (cntVal == '0))
    else $error("restart did not clear count");

  // R8: load strobe places the written value
  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadCnt && !stb.restart) |=> (cntVal == $past(loadVal)))
    else $error("count load lost");

  // R10: divider write does not move the count
  p_psc_keeps_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pscWrite && !stb.loadCnt && !stb.restart) |=> $stable(cntVal))
    else $error("divider write moved count");

endmodule

// File: rtl/uct_ctrl.sv
module uct_ctrl
  import uct_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              updEvent,
  output logic              enable,
  output logic [PSC_W-1:0]  pscVal,
  output logic [CNT_W-1:0]  arrVal,
  output logic [CNT_W-1:0]  loadVal,
  output uctStrobe_t        stb,
  output logic              irqPulse
);

  logic [31:0]       addrW;
  logic              atCtl1, atIrqEn, atStatus, atEvGen, atCount, atPsc, atReload;
  logic [DATA_W-1:0] ctl1Reg;
  logic [DATA_W-1:0] irqEnReg;
  logic              statusFlag;
  logic              statusSet;
  logic [N_STORE-1:0]             storeHit;
  logic [N_STORE-1:0][DATA_W-1:0] storeReg;

  assign addrW    = 32'(busAddr);
  assign atCtl1   = (addrW == OFF_CTL1);
  assign atIrqEn  = (addrW == OFF_IRQEN);
  assign atStatus = (addrW == OFF_STATUS);
  assign atEvGen  = (addrW == OFF_EVGEN);
  assign atCount  = (addrW == OFF_COUNT);
  assign atPsc    = (addrW == OFF_PSC);
  assign atReload = (addrW == OFF_RELOAD);

  assign enable    = ctl1Reg[0];
  assign statusSet = updEvent && irqEnReg[0] && enable;

  assign stb.restart  = busWrEn && atEvGen && busWrData[0];
  assign stb.loadCnt  = busWrEn && atCount;
  assign stb.pscWrite = busWrEn && atPsc;
  assign loadVal      = busWrData[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl1Reg  <= '0;
      irqEnReg <= '0;
      pscVal   <= '0;
      arrVal   <= '0;
    end else if (busWrEn) begin
      if (atCtl1)   ctl1Reg  <= busWrData;
      if (atIrqEn)  irqEnReg <= busWrData;
      if (atPsc)    pscVal   <= busWrData[PSC_W-1:0];
      if (atReload) arrVal   <= busWrData[CNT_W-1:0];
    end
  end

  // sticky flag: hardware sets, software clears with a masked write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusFlag <= 1'b0;
      irqPulse   <= 1'b0;
    end else begin
      irqPulse <= statusSet;
      if (statusSet) begin
        statusFlag <= 1'b1;
      end else if (busWrEn && atStatus) begin
        statusFlag <= statusFlag & busWrData[0];
      end
    end
  end

  // plain storage words
  for (genvar g = 0; g < N_STORE; g++) begin : gStore
    assign storeHit[g] = (addrW == storeOffset(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        storeReg[g] <= '0;
      end else if (busWrEn && storeHit[g]) begin
        storeReg[g] <= busWrData;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (atCtl1)        busRdData = ctl1Reg;
      else if (atIrqEn)  busRdData = irqEnReg;
      else if (atStatus) busRdData = DATA_W'(statusFlag);
      else if (atCount)  busRdData = DATA_W'(cntVal);
      else if (atPsc)    busRdData = DATA_W'(pscVal);
      else if (atReload) busRdData = DATA_W'(arrVal);
      for (int i = 0; i < N_STORE; i++) begin
        if (storeHit[i]) busRdData = storeReg[i];
      end
    end
  end

  // R5: an interrupt pulse always comes with the flag raised
  p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> statusFlag)
    else $error("interrupt without status flag");

  // R5: pulse lasts exactly one clock
  p_irq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse)
    else $error("interrupt held longer than one clock");

  // R6: a 0 written to the flag clears it when no event competes
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && atStatus && !busWrData[0] && !statusSet) |=> !statusFlag)
    else $error("status clear ignored");

  // R9: no interrupt can follow a zero reload value
  p_zero_reload_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(arrVal) != '0))
    else $error("interrupt with zero reload");

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import uct_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 16,
  localparam int CNT_W = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqPulse
);

  logic             enable;
  logic [PSC_W-1:0] pscVal;
  logic [CNT_W-1:0] arrVal;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cntVal;
  logic             updEvent;
  uctStrobe_t       stb;

  uct_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .cntVal(cntVal), .updEvent(updEvent),
    .enable(enable), .pscVal(pscVal), .arrVal(arrVal), .loadVal(loadVal),
    .stb(stb), .irqPulse(irqPulse)
  );

  uct_datapath #(
    .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN),
    .enable(enable), .pscVal(pscVal), .arrVal(arrVal), .loadVal(loadVal),
    .stb(stb), .cntVal(cntVal), .updEvent(updEvent)
  );

endmodule

// File: tb/sim_upcount_timer.sv
module sim_upcount_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  upcount_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqPulse(irqPulse)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic stopAndSetup(input logic [31:0] psc, input logic [31:0] arr,
                              input logic [31:0] ien, input logic [31:0] cnt);
    wr(10'h000, 32'h0);
    wr(10'h028, psc);
    wr(10'h02C, arr);
    wr(10'h00C, ien);
    wr(10'h010, 32'h0);
    wr(10'h024, cnt);
    wr(10'h000, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(10'h000, d); check("R1 control", d, 0);
    rd(10'h00C, d); check("R1 irq enable", d, 0);
    rd(10'h010, d); check("R1 status", d, 0);
    rd(10'h024, d); check("R1 count", d, 0);
    @(negedge clk);
    rd(10'h028, d); check("R1 divider", d, 0);
    rd(10'h02C, d); check("R1 reload", d, 0);
    rd(10'h040, d); check("R1 storage", d, 0);
    check("R1 irq low", 32'(irqPulse), 0);
  endtask

  task automatic testCountRun();
    logic [31:0] d;
    stopAndSetup(0, 1000, 0, 0);
    rd(10'h024, d); check("R3 start", d, 0);
    repeat (5) @(negedge clk);
    rd(10'h024, d); check("R3 divide by one", d, 5);
  endtask

  task automatic testHold();
    logic [31:0] d, held;
    wr(10'h000, 32'h0);
    rd(10'h024, held);
    repeat (6) @(negedge clk);
    rd(10'h024, d); check("R2 hold when stopped", d, held);
  endtask

  task automatic testDivider();
    logic [31:0] d;
    stopAndSetup(2, 1000, 0, 0);
    repeat (2) @(negedge clk);
    rd(10'h024, d); check("R3 before third clock", d, 0);
    @(negedge clk);
    rd(10'h024, d); check("R3 first tick", d, 1);
    repeat (6) @(negedge clk);
    rd(10'h024, d); check("R3 divide by three", d, 3);
  endtask

  task automatic testUpdate();
    logic [31:0] d;
    stopAndSetup(0, 3, 1, 0);
    repeat (3) @(negedge clk);
    rd(10'h024, d); check("R4 at reload", d, 3);
    check("R5 no early irq", 32'(irqPulse), 0);
    @(negedge clk);
    rd(10'h024, d); check("R4 wrapped", d, 0);
    check("R5 irq high", 32'(irqPulse), 1);
    rd(10'h010, d); check("R5 flag set", d, 1);
    @(negedge clk);
    check("R5 irq one clock", 32'(irqPulse), 0);
    rd(10'h024, d); check("R4 after wrap", d, 1);
    wr(10'h000, 32'h0);
  endtask

  task automatic testStatusClear();
    logic [31:0] d;
    wr(10'h010, 32'hFFFF_FFFF);
    rd(10'h010, d); check("R6 write one keeps", d, 1);
    wr(10'h010, 32'hFFFF_FFFE);
    rd(10'h010, d); check("R6 write zero clears", d, 0);
  endtask

  task automatic testNoIrqWhenMasked();
    logic [31:0] d;
    int seen = 0;
    stopAndSetup(0, 3, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (irqPulse) seen++;
    end
    rd(10'h024, d); check("R5 masked wrap count", d, 0);
    check("R5 masked irq", 32'(seen), 0);
    rd(10'h010, d); check("R5 masked flag", d, 0);
  endtask

  task automatic testRestart();
    logic [31:0] d;
    stopAndSetup(0, 1000, 0, 0);
    repeat (5) @(negedge clk);
    wr(10'h014, 32'h1);
    rd(10'h024, d); check("R7 restart zero", d, 0);
    rd(10'h014, d); check("R7 event reads zero", d, 0);
    repeat (2) @(negedge clk);
    rd(10'h024, d); check("R7 counts again", d, 2);
  endtask

  task automatic testLoad();
    logic [31:0] d;
    wr(10'h024, 32'd100);
    rd(10'h024, d); check("R8 loaded", d, 100);
    @(negedge clk);
    rd(10'h024, d); check("R8 counts on", d, 101);
  endtask

  task automatic testPscChange();
    logic [31:0] d, v;
    rd(10'h024, v);
    wr(10'h028, 32'hABCD_0001);
    rd(10'h024, d); check("R10 count kept", d, v + 1);
    rd(10'h028, d); check("R3 divider low half", d, 32'h1);
    @(negedge clk);
    rd(10'h024, d); check("R10 phase restarted", d, v + 1);
    @(negedge clk);
    rd(10'h024, d); check("R10 new ratio", d, v + 2);
  endtask

  task automatic testZeroReload();
    logic [31:0] d;
    int seen = 0;
    stopAndSetup(0, 0, 1, 32'hFFFF_FFFE);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (irqPulse) seen++;
    end
    rd(10'h024, d); check("R9 silent rollover", d, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (irqPulse) seen++;
    end
    check("R9 no irq", 32'(seen), 0);
    rd(10'h010, d); check("R9 no flag", d, 0);
    wr(10'h000, 32'h0);
  endtask

  task automatic testMap();
    logic [31:0] d;
    wr(10'h004, 32'h0000_1234);
    wr(10'h050, 32'h55AA_55AA);
    wr(10'h030, 32'hDEAD_BEEF);
    wr(10'h3FC, 32'hCAFE_F00D);
    wr(10'h006, 32'h1111_1111);
    rd(10'h004, d); check("R11 storage low", d, 32'h0000_1234);
    rd(10'h050, d); check("R11 storage high", d, 32'h55AA_55AA);
    rd(10'h030, d); check("R11 hole reads zero", d, 0);
    @(negedge clk);
    rd(10'h3FC, d); check("R11 top reads zero", d, 0);
    rd(10'h006, d); check("R11 misaligned zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountRun();
    testHold();
    testDivider();
    testUpdate();
    testStatusClear();
    testNoIrqWhenMasked();
    testRestart();
    testLoad();
    testPscChange();
    testZeroReload();
    testMap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all requirements: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule